// File: doc/BRIEF.md
# Level-Qualified Interrupt Status Collector

This block sits on the host side of a low-pin-count bus controller. It gathers a set of device interrupt request lines, one per bit, and latches a sticky status bit for each line while that line is high. A mask register chooses which latched bits may raise the single interrupt sent to the processor interrupt controller. Software reads the status register to find pending sources and acknowledges them by writing ones.

The live level of every request line is first captured in an internal level register, kept apart from the status register that software sees. An acknowledge write clears a status bit only when that bit's captured level is low. A source that still holds its line high therefore keeps its status bit set, and a level interrupt cannot be lost by an early acknowledge. The register port is a plain single-cycle write strobe with a combinational read. Nothing flows through the block as a data stream, so it has no valid/ready handshake.

Top module: `irq_status_hub`

## Requirements
- R1: While reset is held, and right after it is released, the status register and the mask register read as zero and `irq_o` is low.
- R2: A request line held high sets its status bit. The bit first reads as 1 in the second clock after the line rises, because the level is captured one clock before it is latched.
- R3: A status bit stays set after its request line falls, until software clears it.
- R4: A write to offset 0 clears each status bit written as 1 whose captured level is low, and it does so at that clock edge. Bits written as 0 are unchanged.
- R5: A clear for a bit whose captured level is high has no effect. When a clear and a set meet in the same cycle, the bit stays set.
- R6: A write to offset 4 replaces the whole mask, and reading offset 4 returns it. A mask bit of 1 enables its line.
- R7: `irq_o` is a register that holds the OR over all bits of status AND mask. It follows a change in status or mask one clock later.
- R8: A write to any offset other than 0 or 4 changes neither status nor mask. A read of any such offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_lines | input | N_LINES | Device interrupt request levels, one per bit |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte offset of the register: 0 for status, 4 for mask |
| reg_wdata | input | N_LINES | Write data: ones to clear at offset 0, new mask at offset 4 |
| reg_rdata | output | N_LINES | Combinational read data for `reg_addr` |
| irq_o | output | 1 | Registered interrupt toward the processor |

## Verification
Two low lines are raised together with the mask at zero. This shows that latching does not depend on the mask and that the raised bits are the only ones set. An acknowledge of both bits while they are still high is then compared with a partial acknowledge after they have fallen, which separates the level-qualified clear from plain write-one-to-clear and shows that bits written as zero are left alone. A single top line is raised with every mask bit open and the interrupt is sampled on each of the following clocks, so an extra or a missing pipeline stage shows up as a wrong value in a named cycle. Writes to an unused offset are followed by reads of both registers and of that offset.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
  localparam int OFS_STATUS = 0;
  localparam int OFS_MASK   = 4;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_MASK
  } reg_sel_e;
endpackage

// File: rtl/irqs_line_sample.sv
// Captures the live request levels into the internal level register.
module irqs_line_sample #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lines_i,
  output logic [N-1:0] level_o
);
  always_ff @(posedge clk) begin
    if (rst) level_o <= '0;
    else     level_o <= lines_i;
  end
endmodule

// File: rtl/irqs_status_array.sv
// One sticky status bit per line; a high level beats a clear request.
module irqs_status_array #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] level_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)             status_o[g] <= 1'b0;
      else if (level_i[g]) status_o[g] <= 1'b1;
      else if (clr_i[g])   status_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irqs_regport.sv
// Address decode, mask storage, clear vector and read mux.
module irqs_regport
  import irqs_pkg::*;
#(
  parameter int N  = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [N-1:0]  wdata_i,
  input  logic [N-1:0]  status_i,
  output logic [N-1:0]  rdata_o,
  output logic [N-1:0]  clr_o,
  output logic [N-1:0]  mask_o
);
  localparam logic [AW-1:0] ADDR_ST = AW'(OFS_STATUS);
  localparam logic [AW-1:0] ADDR_MK = AW'(OFS_MASK);

  reg_sel_e sel;

  always_comb begin
    if (addr_i == ADDR_ST)      sel = SEL_STATUS;
    else if (addr_i == ADDR_MK) sel = SEL_MASK;
    else                        sel = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst)                         mask_o <= '0;
    else if (wr_i && sel == SEL_MASK) mask_o <= wdata_i;
  end

  assign clr_o = (wr_i && sel == SEL_STATUS) ? wdata_i : '0;

  always_comb begin
    unique case (sel)
      SEL_STATUS: rdata_o = status_i;
      SEL_MASK:   rdata_o = mask_o;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_hub.sv
module irq_status_hub #(
  parameter int N_LINES = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_lines,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [N_LINES-1:0] reg_wdata,
  output logic [N_LINES-1:0] reg_rdata,
  output logic               irq_o
);
  logic [N_LINES-1:0] level_q;
  logic [N_LINES-1:0] stat_q;
  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] clr_vec;

  irqs_line_sample #(.N(N_LINES)) u_sample (
    .clk(clk), .rst(rst), .lines_i(irq_lines), .level_o(level_q)
  );

  irqs_status_array #(.N(N_LINES)) u_status (
    .clk(clk), .rst(rst), .level_i(level_q), .clr_i(clr_vec), .status_o(stat_q)
  );

  irqs_regport #(.N(N_LINES), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .status_i(stat_q), .rdata_o(reg_rdata), .clr_o(clr_vec), .mask_o(mask_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(stat_q & mask_q);
  end
endmodule

// File: rtl/irqs_checker.sv
module irqs_checker #(
  parameter int N  = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [N-1:0]  reg_wdata,
  input logic          irq_o,
  input logic [N-1:0]  level_q,
  input logic [N-1:0]  stat_q,
  input logic [N-1:0]  mask_q
);
  localparam logic [AW-1:0] A_ST = AW'(0);
  localparam logic [AW-1:0] A_MK = AW'(4);

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (stat_q == '0 && mask_q == '0 && !irq_o));

  // R2 and R5: a captured high level leaves its status bit set
  assert_level_set_R5: assert property (@(posedge clk) disable iff (rst)
    (level_q != '0) |=> ((stat_q & $past(level_q)) == $past(level_q)));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == A_ST) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_mask_write_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_MK) |=> (mask_q == $past(reg_wdata)));

  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == A_MK) |=> $stable(mask_q));

  assert_irq_follow_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == |($past(stat_q) & $past(mask_q))));
endmodule

bind irq_status_hub irqs_checker #(.N(N_LINES), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq_o(irq_o), .level_q(level_q),
  .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/sim_irq_status_hub.sv
`timescale 1ns/1ps
module sim_irq_status_hub;
  localparam int N  = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_lines = '0;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [N-1:0]  reg_wdata = '0;
  logic [N-1:0]  reg_rdata;
  logic          irq_o;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  probe  = 1'b0;
  bit  done   = 1'b0;

  // scoreboard queues: kind 0 = read data, kind 1 = interrupt pin
  bit          kind_q[$];
  logic [N-1:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  irq_status_hub #(.N_LINES(N), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o)
  );

  // monitor
  always @(negedge clk) begin
    if (probe && exp_q.size() > 0) begin
      bit           k;
      logic [N-1:0] e;
      logic [N-1:0] got;
      string        t;
      k = kind_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      got = k ? N'(irq_o) : reg_rdata;
      n_run++;
      if (got !== e) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", t, got, e);
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  // driver: push the expectation, then present the probe for one sample
  task automatic chk(input bit k, input logic [AW-1:0] a,
                     input logic [N-1:0] e, input string t);
    @(posedge clk); #1;
    reg_addr = a;
    kind_q.push_back(k); exp_q.push_back(e); tag_q.push_back(t);
    probe = 1'b1;
    @(negedge clk); #1;
    probe = 1'b0;
  endtask

  initial begin
    tick(3);
    chk(0, 4'd0, '0, "R1 status after reset");
    chk(0, 4'd4, '0, "R1 mask after reset");
    chk(1, 4'd0, '0, "R1 irq after reset");
    rst = 1'b0;
    chk(0, 4'd0, '0, "R1 status after release");

    irq_lines = 32'h0000_0005;
    tick(2);
    chk(0, 4'd0, 32'h0000_0005, "R2 lines 0 and 2 latched");
    chk(1, 4'd0, '0, "R7 irq low with mask zero");

    wr(4'd0, 32'h0000_0005);
    chk(0, 4'd0, 32'h0000_0005, "R5 clear ignored while lines high");

    irq_lines = '0;
    tick(2);
    chk(0, 4'd0, 32'h0000_0005, "R3 bits stay after lines fall");

    wr(4'd0, 32'h0000_0001);
    chk(0, 4'd0, 32'h0000_0004, "R4 bit 0 cleared, bit 2 kept");

    wr(4'd4, 32'h0000_0004);
    chk(0, 4'd4, 32'h0000_0004, "R6 mask read back");
    chk(1, 4'd0, 1, "R7 irq from bit 2");

    wr(4'd0, 32'h0000_0004);
    chk(1, 4'd0, 0, "R7 irq drops one clock after clear");
    chk(0, 4'd0, '0, "R4 status empty");

    wr(4'd8, 32'hFFFF_FFFF);
    chk(0, 4'd4, 32'h0000_0004, "R8 mask unchanged by unused offset");
    chk(0, 4'd0, '0, "R8 status unchanged by unused offset");
    chk(0, 4'd8, '0, "R8 unused offset reads zero");

    wr(4'd4, 32'hFFFF_FFFF);
    tick(1);
    irq_lines = 32'h8000_0000;
    chk(1, 4'd0, 0, "R7 irq low one clock after line rise");
    chk(1, 4'd0, 0, "R2 irq low two clocks after line rise");
    chk(1, 4'd0, 1, "R7 irq high three clocks after line rise");
    chk(0, 4'd0, 32'h8000_0000, "R2 bit 31 latched");

    irq_lines = '0;
    tick(2);
    wr(4'd0, 32'hFFFF_FFFF);
    chk(0, 4'd0, '0, "R4 bit 31 cleared after line fell");
    chk(1, 4'd0, 0, "R7 irq low after clear");

    tick(2);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule